// File: doc/BRIEF.md
# Fractional-Sample All-Pass Delay Filter

This block delays a fixed-point sample stream by a non-integer number of samples. It uses a recursive all-pass filter of order 1 to 3 in which the feed-forward coefficients are the feedback coefficients in reverse order. The gain stays at unity at every frequency, and the phase of the feedback polynomial sets the delay. The coefficients follow the maximally flat group-delay rule, so the group delay is flattest at low frequency.

Each valid input sample produces one output sample one clock later. There are two ways to load coefficients. Software can write them one at a time into a shadow set. Or the block can take a complete set from a built-in table of eight delay steps, computed when the design is elaborated. In both cases the new set becomes active only in a cycle that carries no input sample, so a sample is never filtered with a mix of old and new coefficients. The filter history is kept across a coefficient change.

Top module: `thiran_allpass`

## Requirements
- R1: After reset, out_valid and out_data are 0, the history is zero and the active coefficients a1..aN are all 0, so the filter is a pure N-sample delay.
- R2: Each cycle with in_valid high produces exactly one out_valid pulse in the next cycle, with samples in order. Outside those pulses out_data holds its last value.
- R3: The output for an input x[n] is a_N·x[n] + … + a_1·x[n−N+1] + a_0·x[n−N] − a_1·y[n−1] − … − a_N·y[n−N]. Here a_0 = 1.0 and every coefficient is a signed Q2.14 value, so 16384 means 1.0.
- R4: The Q·14 sum is rounded to the nearest integer, with halves rounded upward (toward +infinity): 1.5 becomes 2 and −1.5 becomes −1.
- R5: The rounded result is saturated to the range −32768..32767. The saturated value is what goes out and what is fed back as y.
- R6: In table mode, delay step s (0..7) selects the delay D = N + (s−4)/8. In that mode a_k = (−1)^k·C(N,k)·Π_{n=0..N}(D−N+n)/(D−N+k+n), rounded to the nearest Q2.14 value. Step 4 gives all zeros, which is an exact N-sample delay.
- R7: A write with cfg_idx = k (1..N) stores cfg_data as the shadow value of a_k. A write with cfg_idx = 0 is ignored. Writes alone do not change the output; the shadow set takes effect only through a commit with cfg_use_table low.
- R8: A commit captures the source (shadow or table step) and waits. The swap happens at the first clock edge after the commit at which in_valid is low. Samples taken in the commit cycle and up to that edge use the old set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| cfg_wr | input | 1 | Shadow coefficient write strobe |
| cfg_idx | input | clog2(ORDER+1) | Coefficient index k (1..ORDER) |
| cfg_data | input | 16 | Signed Q2.14 coefficient value |
| cfg_use_table | input | 1 | Commit source: 1 = table, 0 = shadow set |
| cfg_delay_sel | input | 3 | Table delay step s |
| cfg_commit | input | 1 | Request a coefficient swap |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW | Signed filtered output sample |

## Verification
The delicate case is a coefficient commit that arrives in the same cycle as an input sample, or while samples keep arriving. To provoke it, the bench holds in_valid high through a commit and several following samples, then inserts a single idle cycle. The scoreboard filters every sample taken before that idle cycle with the old set and every later sample with the new one. Any early, late or partial swap shows up as a mismatch in the recursive output, and the history carries the error forward.

// File: rtl/thiran_pkg.sv
package thiran_pkg;

  localparam int COEF_W     = 16;
  localparam int COEF_FRAC  = 14;
  localparam int SEL_W      = 3;
  localparam int SEL_CNT    = 1 << SEL_W;
  localparam int SEL_CENTER = SEL_CNT / 2;

  function automatic longint binom(int n, int k);
    longint r;
    r = 1;
    for (int i = 1; i <= k; i++) r = r * longint'(n - k + i) / longint'(i);
    return r;
  endfunction

  // a_k for delay D = order + step/SEL_CNT, rounded to nearest Q2.14 (halves up)
  function automatic logic [COEF_W-1:0] thiran_q14(int order, int step, int k);
    longint num, den, v, t, q;
    num = 1;
    den = 1;
    for (int n = 0; n <= order; n++) begin
      num = num * longint'(step + SEL_CNT * n);
      den = den * longint'(step + SEL_CNT * (k + n));
    end
    v = num * binom(order, k) * (longint'(1) << COEF_FRAC);
    if ((k % 2) == 1) v = -v;
    t = 2 * v + den;
    if (t >= 0) q = t / (2 * den);
    else        q = -((-t + 2 * den - 1) / (2 * den));
    return q[COEF_W-1:0];
  endfunction

endpackage

// File: rtl/thiran_coef_rom.sv
module thiran_coef_rom
  import thiran_pkg::*;
#(
  parameter int ORDER = 3
) (
  input  logic [SEL_W-1:0]              sel,
  output logic [ORDER-1:0][COEF_W-1:0]  coef
);

  logic [SEL_CNT-1:0][ORDER-1:0][COEF_W-1:0] table_q;

  for (genvar s = 0; s < SEL_CNT; s++) begin : g_step
    for (genvar k = 0; k < ORDER; k++) begin : g_coef
      localparam logic [COEF_W-1:0] VAL = thiran_q14(ORDER, s - SEL_CENTER, k + 1);
      assign table_q[s][k] = VAL;
    end
  end

  assign coef = table_q[sel];

endmodule

// File: rtl/thiran_coef_bank.sv
module thiran_coef_bank
  import thiran_pkg::*;
#(
  parameter int ORDER = 3,
  localparam int IDX_W = $clog2(ORDER + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sample_valid,
  input  logic                          cfg_wr,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [COEF_W-1:0]             cfg_data,
  input  logic                          cfg_use_table,
  input  logic [SEL_W-1:0]              cfg_delay_sel,
  input  logic                          cfg_commit,
  output logic [SEL_W-1:0]              rom_sel,
  input  logic [ORDER-1:0][COEF_W-1:0]  rom_coef,
  output logic [ORDER-1:0][COEF_W-1:0]  act_coef
);

  logic [ORDER-1:0][COEF_W-1:0] shadow_q;
  logic                         pend_q;
  logic                         pend_tab_q;
  logic [SEL_W-1:0]             pend_sel_q;
  logic                         apply;

  assign rom_sel = pend_sel_q;
  assign apply   = pend_q && !sample_valid && !cfg_commit;

  for (genvar k = 0; k < ORDER; k++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)
        shadow_q[k] <= '0;
      else if (cfg_wr && cfg_idx == IDX_W'(k + 1))
        shadow_q[k] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_tab_q <= 1'b0;
      pend_sel_q <= SEL_W'(SEL_CENTER);
      act_coef   <= '0;
    end else if (cfg_commit) begin
      pend_q     <= 1'b1;
      pend_tab_q <= cfg_use_table;
      pend_sel_q <= cfg_delay_sel;
    end else if (apply) begin
      pend_q   <= 1'b0;
      act_coef <= pend_tab_q ? rom_coef : shadow_q;
    end
  end

  // R8: the active set never changes across an edge that took a sample
  p_swap_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_coef) |-> !$past(sample_valid));

  // R8: a waiting swap completes at the first idle edge
  p_pend_done_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !sample_valid && !cfg_commit) |=> !pend_q);

endmodule

// File: rtl/thiran_datapath.sv
module thiran_datapath
  import thiran_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int DW    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic signed [DW-1:0]          in_data,
  input  logic [ORDER-1:0][COEF_W-1:0]  coef,
  output logic                          out_valid,
  output logic signed [DW-1:0]          out_data
);

  localparam int PW    = DW + COEF_W;
  localparam int ACC_W = PW + $clog2(2 * ORDER + 1) + 1;
  localparam logic signed [COEF_W-1:0] ONE = COEF_W'(1 << COEF_FRAC);

  logic signed [DW-1:0]     xh [ORDER];
  logic signed [DW-1:0]     yh [ORDER];
  logic signed [DW-1:0]     xfull [ORDER+1];
  logic signed [COEF_W-1:0] cfull [ORDER+1];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rnd;
  logic signed [ACC_W-1:0]  sh;
  logic signed [DW-1:0]     y_next;
  logic                     ovf;

  always_comb begin
    xfull[0] = in_data;
    cfull[0] = ONE;
    for (int j = 1; j <= ORDER; j++) begin
      xfull[j] = xh[j-1];
      cfull[j] = coef[j-1];
    end
  end

  always_comb begin
    logic signed [PW-1:0] p;
    acc = '0;
    for (int j = 0; j <= ORDER; j++) begin
      p   = xfull[j] * cfull[ORDER-j];
      acc = acc + {{(ACC_W-PW){p[PW-1]}}, p};
    end
    for (int k = 1; k <= ORDER; k++) begin
      p   = yh[k-1] * cfull[k];
      acc = acc - {{(ACC_W-PW){p[PW-1]}}, p};
    end
  end

  always_comb begin
    rnd = acc + ACC_W'(1 << (COEF_FRAC - 1));
    sh  = rnd >>> COEF_FRAC;
    ovf = !((&sh[ACC_W-1:DW-1]) || !(|sh[ACC_W-1:DW-1]));
    if (ovf)
      y_next = sh[ACC_W-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      y_next = sh[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < ORDER; i++) begin
        xh[i] <= '0;
        yh[i] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= y_next;
        xh[0]    <= in_data;
        yh[0]    <= y_next;
        for (int i = 1; i < ORDER; i++) begin
          xh[i] <= xh[i-1];
          yh[i] <= yh[i-1];
        end
      end
    end
  end

  // R3: the newest input enters the input history after a sample
  p_hist_in_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (xh[0] == $past(in_data)));

  // R2: output holds when no sample is taken
  p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

endmodule

// File: rtl/thiran_allpass.sv
module thiran_allpass
  import thiran_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(ORDER + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [DW-1:0]  in_data,
  input  logic                  cfg_wr,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [COEF_W-1:0]     cfg_data,
  input  logic                  cfg_use_table,
  input  logic [SEL_W-1:0]      cfg_delay_sel,
  input  logic                  cfg_commit,
  output logic                  out_valid,
  output logic signed [DW-1:0]  out_data
);

  logic [SEL_W-1:0]             rom_sel;
  logic [ORDER-1:0][COEF_W-1:0] rom_coef;
  logic [ORDER-1:0][COEF_W-1:0] act_coef;

  thiran_coef_rom #(.ORDER(ORDER)) u_rom (
    .sel  (rom_sel),
    .coef (rom_coef)
  );

  thiran_coef_bank #(.ORDER(ORDER)) u_bank (
    .clk           (clk),
    .rst           (rst),
    .sample_valid  (in_valid),
    .cfg_wr        (cfg_wr),
    .cfg_idx       (cfg_idx),
    .cfg_data      (cfg_data),
    .cfg_use_table (cfg_use_table),
    .cfg_delay_sel (cfg_delay_sel),
    .cfg_commit    (cfg_commit),
    .rom_sel       (rom_sel),
    .rom_coef      (rom_coef),
    .act_coef      (act_coef)
  );

  thiran_datapath #(.ORDER(ORDER), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .coef      (act_coef),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R2: every accepted sample yields an output strobe next cycle
  p_one_out_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

endmodule

// File: tb/thiran_allpass_tb.sv
module thiran_allpass_tb;

  localparam int ORD = 3;
  localparam int DW  = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 cfg_wr = 1'b0;
  logic [1:0]           cfg_idx = '0;
  logic [15:0]          cfg_data = '0;
  logic                 cfg_use_table = 1'b0;
  logic [2:0]           cfg_delay_sel = '0;
  logic                 cfg_commit = 1'b0;
  logic                 out_valid;
  logic signed [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mc [0:ORD];
  int sh_m [1:ORD];
  int mx [1:ORD];
  int my [1:ORD];
  int exp_q [$];
  string tag_q [$];
  int prev_out;

  always #2.5 clk = ~clk;

  thiran_allpass #(.ORDER(ORD), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cfg_use_table(cfg_use_table), .cfg_delay_sel(cfg_delay_sel),
    .cfg_commit(cfg_commit), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int ref_coef(int s, int k);
    real p;
    real a;
    real b;
    p = 1.0;
    b = 1.0;
    for (int i = 1; i <= k; i++) b = b * real'(ORD - k + i) / real'(i);
    for (int n = 0; n <= ORD; n++)
      p = p * real'(s - 4 + 8 * n) / real'(s - 4 + 8 * (k + n));
    a = ((k % 2) == 1 ? -1.0 : 1.0) * b * p;
    return int'($floor(a * 16384.0 + 0.5));
  endfunction

  function automatic int model_step(int x);
    longint acc;
    longint y;
    acc = longint'(x) * mc[ORD];
    for (int j = 1; j <= ORD; j++) acc += longint'(mx[j]) * mc[ORD-j];
    for (int k = 1; k <= ORD; k++) acc -= longint'(my[k]) * mc[k];
    y = (acc + 8192) >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    for (int j = ORD; j >= 2; j--) begin
      mx[j] = mx[j-1];
      my[j] = my[j-1];
    end
    mx[1] = x;
    my[1] = int'(y);
    return int'(y);
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send(int x, string tag);
    @(negedge clk);
    cfg_commit = 1'b0;
    cfg_wr     = 1'b0;
    in_valid   = 1'b1;
    in_data    = 16'(x);
    exp_q.push_back(model_step(x));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      cfg_commit = 1'b0;
      cfg_wr     = 1'b0;
    end
  endtask

  task automatic wr_coef(int idx, int val);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_wr   = 1'b1;
    cfg_idx  = 2'(idx);
    cfg_data = 16'(val);
    if (idx >= 1 && idx <= ORD) sh_m[idx] = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic commit_table(int s);
    @(negedge clk);
    in_valid      = 1'b0;
    cfg_commit    = 1'b1;
    cfg_use_table = 1'b1;
    cfg_delay_sel = 3'(s);
    idle(2);
    for (int k = 1; k <= ORD; k++) mc[k] = ref_coef(s, k);
  endtask

  task automatic commit_shadow();
    @(negedge clk);
    in_valid      = 1'b0;
    cfg_commit    = 1'b1;
    cfg_use_table = 1'b0;
    idle(2);
    for (int k = 1; k <= ORD; k++) mc[k] = sh_m[k];
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R2 actual=%0d expected=no output", int'(out_data));
        end else begin
          string t;
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'(out_data), e);
        end
      end else begin
        check("R2", int'(out_data), prev_out);
      end
      prev_out = int'(out_data);
    end else begin
      prev_out = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mc[0] = 16384;
    for (int k = 1; k <= ORD; k++) begin
      mc[k] = 0; sh_m[k] = 0; mx[k] = 0; my[k] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    rst = 1'b0;
    idle(1);

    // R1: reset coefficients give a pure N-sample delay
    for (int i = 1; i <= 7; i++) send(i * 1000 - 3500, "R1");
    idle(3);

    // R6: table extremes and an interior step
    commit_table(0);
    for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 12000 : -7000 + i * 311, "R6");
    idle(2);
    commit_table(7);
    for (int i = 0; i < 10; i++) send(i * 2500 - 9000, "R6");
    idle(2);
    // R3: generic recursion with step 2
    commit_table(2);
    send(20000, "R3");
    for (int i = 0; i < 10; i++) send(0, "R3");
    idle(2);

    // R7: shadow writes alone do not alter output; index 0 ignored
    wr_coef(1, 0);
    wr_coef(2, 0);
    wr_coef(3, 8192);
    wr_coef(0, 12345);
    for (int i = 0; i < 5; i++) send(i * 777, "R7");
    idle(2);
    commit_shadow();
    // R4: half values rounded upward (0.5*odd inputs)
    send(3, "R4");
    send(-3, "R4");
    send(5, "R4");
    send(-5, "R4");
    send(1, "R4");
    send(-1, "R4");
    for (int i = 0; i < 4; i++) send(0, "R4");
    idle(2);

    // R5: saturation, saturated value fed back
    wr_coef(3, 32767);
    commit_shadow();
    send(30000, "R5");
    send(30000, "R5");
    send(-30000, "R5");
    send(-30000, "R5");
    for (int i = 0; i < 6; i++) send(29000, "R5");
    idle(2);

    // R8: commit in the same cycle as a sample; stream continues, then one gap
    wr_coef(1, -4000);
    wr_coef(2, 2000);
    wr_coef(3, 1000);
    @(negedge clk);
    cfg_wr        = 1'b0;
    in_valid      = 1'b1;
    in_data       = 16'(1500);
    cfg_commit    = 1'b1;
    cfg_use_table = 1'b0;
    exp_q.push_back(model_step(1500));
    tag_q.push_back("R8");
    for (int i = 0; i < 5; i++) send(-2000 + i * 900, "R8");
    idle(1);
    for (int k = 1; k <= ORD; k++) mc[k] = sh_m[k];
    for (int i = 0; i < 8; i++) send(3000 - i * 700, "R8");
    idle(4);

    // R2: every sample produced exactly one output
    check("R2", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule